// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block watches every instruction of a small 16-bit CPU and raises a break request when that instruction hits one of six hardware breakpoints. It also holds the byte-wide debug control register that governs the breakpoints. That register has three fields. A master break enable (bit 7) can be changed only while the CPU is in background debug mode. A register-mode select (bit 5) can be written at any time. A 4-bit host command field (bits 3:0) is loaded only by the debug engine.

In address mode (bit 5 = 0), all six breakpoints compare against the instruction address. In register mode (bit 5 = 1), breakpoints 0 to 3 still compare against the address, and the last two change role. Breakpoint 4 matches the destination register address of the instruction. Breakpoint 5 matches the destination register address only when the data written also fits a masked pattern. The break request is registered. It lasts one clock, is blocked while the master enable is clear, and is blocked while the CPU is already in debug mode.

Top module: `bkpt_match_unit`

## Requirements
- R1: After reset, `ctrl_rdata` is 0x00, `break_req` is 0 and `invalid_cmd` is 0.
- R2: While control bit 7 (master enable) is 0, `break_req` stays 0 even when an instruction matches a breakpoint. Host commands are still loaded in this state.
- R3: A control write changes bit 7 only if `bg_mode` is 1 in the cycle of the write. A control write made with `bg_mode` at 0 leaves bit 7 unchanged.
- R4: With bit 7 = 1 and bit 5 = 0, an instruction (`instr_valid` = 1) whose `instr_addr` equals any of the six breakpoint values makes `break_req` 1 in the next cycle. A non-matching instruction leaves `break_req` at 0 in that cycle.
- R5: With bit 5 = 1, breakpoint 4 matches when `instr_valid` and `dst_valid` are 1 and `dst_addr` equals the low 8 bits of breakpoint 4. Breakpoints 4 and 5 then no longer match on `instr_addr`, but breakpoints 0 to 3 still do.
- R6: With bit 5 = 1, breakpoint 5 matches when `instr_valid` and `dst_valid` are 1, `dst_addr` equals its low 8 bits, and ((`dst_data` XOR pattern) AND mask) == 0. Pattern is configuration select 6 and mask is select 7. Selects 0 to 5 are the breakpoints.
- R7: Bit 5 set while bit 7 is 0 never produces a break.
- R8: Bits 3:0 change only through `host_cmd_we`. A CPU control write leaves them unchanged, and it writes bit 5 whatever the value of `bg_mode`.
- R9: `invalid_cmd` is 1 exactly when bits 3:0 hold a code other than 0000, 0001, 0010, 0011, 0100, 0101, 1000 or 1001. Such a code is still stored.
- R10: Control bits 6 and 4 always read 0, even after a write of ones.
- R11: While `dbg_mode` is 1, a matching instruction gives no break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for breakpoint, pattern and mask registers |
| cfg_sel | input | 3 | Target: 0-5 breakpoint, 6 pattern, 7 mask |
| cfg_wdata | input | 16 | Configuration write value |
| ctrl_we | input | 1 | CPU write strobe for the control register |
| ctrl_wdata | input | 8 | CPU control write value |
| bg_mode | input | 1 | CPU is in background debug mode |
| dbg_mode | input | 1 | CPU is already halted in debug mode |
| host_cmd_we | input | 1 | Debug engine loads the command field |
| host_cmd | input | 4 | Command code from the debug engine |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr_addr | input | 16 | Address of the instruction |
| dst_valid | input | 1 | The instruction writes a destination register |
| dst_addr | input | 8 | Destination register address |
| dst_data | input | 16 | Data written to the destination |
| break_req | output | 1 | One-cycle registered break request |
| ctrl_rdata | output | 8 | Control register readback |
| invalid_cmd | output | 1 | Command field holds a reserved code |

## Verification
`break_req` is due one cycle after the instruction inputs that cause it. `ctrl_rdata` and `invalid_cmd` are due one cycle after the write that changes them. A driver task applies each cycle's inputs on the falling edge and pushes one expected break value for that cycle. The monitor pops one entry 1 ns after every rising edge, so each expectation is compared against the edge that registers it. Register readbacks are sampled on the falling edge that follows the write edge, after the write task returns.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int CMD_W     = 4;
    localparam int CTRL_W    = 8;
    localparam int EN_BIT    = 7;
    localparam int RMODE_BIT = 5;

    typedef enum logic [CMD_W-1:0] {
        HC_NOP      = 4'h0,
        HC_RD_MAP   = 4'h1,
        HC_RD_DATA  = 4'h2,
        HC_RD_STACK = 4'h3,
        HC_WR_REG   = 4'h4,
        HC_WR_DATA  = 4'h5,
        HC_UNLOCK   = 4'h8,
        HC_RD_REG   = 4'h9
    } host_cmd_e;

    function automatic logic cmd_known(input logic [CMD_W-1:0] c);
        logic ok;
        case (c)
            HC_NOP, HC_RD_MAP, HC_RD_DATA, HC_RD_STACK,
            HC_WR_REG, HC_WR_DATA, HC_UNLOCK, HC_RD_REG: ok = 1'b1;
            default:                                     ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/bkpt_cfg_regs.sv
module bkpt_cfg_regs
    import bkpt_pkg::*;
#(
    parameter int NUM_BP = 6,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int SEL_W  = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cfg_we,
    input  logic [SEL_W-1:0]               cfg_sel,
    input  logic [DATA_W-1:0]              cfg_wdata,
    input  logic                           ctrl_we,
    input  logic [CTRL_W-1:0]              ctrl_wdata,
    input  logic                           bg_mode,
    input  logic                           host_cmd_we,
    input  logic [CMD_W-1:0]               host_cmd,
    output logic [NUM_BP-1:0][ADDR_W-1:0]  bp_o,
    output logic [DATA_W-1:0]              pat_o,
    output logic [DATA_W-1:0]              mask_o,
    output logic                           en_o,
    output logic                           rmode_o,
    output logic [CMD_W-1:0]               cmd_o
);
    localparam logic [SEL_W-1:0] PAT_SEL  = SEL_W'(NUM_BP);
    localparam logic [SEL_W-1:0] MASK_SEL = SEL_W'(NUM_BP + 1);

    typedef struct packed {
        logic [NUM_BP-1:0][ADDR_W-1:0] bp;
        logic [DATA_W-1:0]             pat;
        logic [DATA_W-1:0]             mask;
        logic                          en;
        logic                          rmode;
        logic [CMD_W-1:0]              cmd;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            for (int i = 0; i < NUM_BP; i++) begin
                if (cfg_sel == SEL_W'(i)) st_d.bp[i] = cfg_wdata[ADDR_W-1:0];
            end
            if (cfg_sel == PAT_SEL)  st_d.pat  = cfg_wdata;
            if (cfg_sel == MASK_SEL) st_d.mask = cfg_wdata;
        end
        if (ctrl_we) begin
            st_d.rmode = ctrl_wdata[RMODE_BIT];
            if (bg_mode) st_d.en = ctrl_wdata[EN_BIT];
        end
        if (host_cmd_we) st_d.cmd = host_cmd;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign bp_o    = st_q.bp;
    assign pat_o   = st_q.pat;
    assign mask_o  = st_q.mask;
    assign en_o    = st_q.en;
    assign rmode_o = st_q.rmode;
    assign cmd_o   = st_q.cmd;

    // R3: master enable moves only after a control write in background mode
    p_en_guard_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(ctrl_we && bg_mode) |-> $stable(en_o));

    // R8: the command field moves only through the host load port
    p_cmd_host_only_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(host_cmd_we) |-> $stable(cmd_o));

endmodule

// File: rtl/bkpt_comparator.sv
module bkpt_comparator #(
    parameter int NUM_BP = 6,
    parameter int ADDR_W = 16,
    parameter int REG_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic [NUM_BP-1:0][ADDR_W-1:0] bp,
    input  logic [DATA_W-1:0]             pat,
    input  logic [DATA_W-1:0]             mask,
    input  logic                          rmode,
    input  logic                          instr_valid,
    input  logic [ADDR_W-1:0]             instr_addr,
    input  logic                          dst_valid,
    input  logic [REG_W-1:0]              dst_addr,
    input  logic [DATA_W-1:0]             dst_data,
    output logic [NUM_BP-1:0]             hit_vec
);
    localparam int REG_A = NUM_BP - 2;
    localparam int REG_B = NUM_BP - 1;

    logic reg_write;
    logic data_fits;

    assign reg_write = instr_valid && dst_valid;
    assign data_fits = (((dst_data ^ pat) & mask) == '0);

    for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
        logic addr_eq;
        logic reg_eq;
        assign addr_eq = instr_valid && (bp[i] == instr_addr);
        assign reg_eq  = reg_write && (bp[i][REG_W-1:0] == dst_addr);
        if (i == REG_A) begin : g_reg_only
            assign hit_vec[i] = rmode ? reg_eq : addr_eq;
        end else if (i == REG_B) begin : g_reg_data
            assign hit_vec[i] = rmode ? (reg_eq && data_fits) : addr_eq;
        end else begin : g_addr
            assign hit_vec[i] = addr_eq;
        end
    end

endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
    import bkpt_pkg::*;
#(
    parameter int NUM_BP = 6,
    parameter int ADDR_W = 16,
    parameter int REG_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [$clog2(NUM_BP+2)-1:0]   cfg_sel,
    input  logic [DATA_W-1:0]             cfg_wdata,
    input  logic                          ctrl_we,
    input  logic [7:0]                    ctrl_wdata,
    input  logic                          bg_mode,
    input  logic                          dbg_mode,
    input  logic                          host_cmd_we,
    input  logic [3:0]                    host_cmd,
    input  logic                          instr_valid,
    input  logic [ADDR_W-1:0]             instr_addr,
    input  logic                          dst_valid,
    input  logic [REG_W-1:0]              dst_addr,
    input  logic [DATA_W-1:0]             dst_data,
    output logic                          break_req,
    output logic [7:0]                    ctrl_rdata,
    output logic                          invalid_cmd
);
    localparam int SEL_W = $clog2(NUM_BP + 2);

    logic [NUM_BP-1:0][ADDR_W-1:0] bp;
    logic [DATA_W-1:0]             pat;
    logic [DATA_W-1:0]             mask;
    logic                          en;
    logic                          rmode;
    logic [CMD_W-1:0]              cmd;
    logic [NUM_BP-1:0]             hit_vec;
    logic                          any_hit;

    bkpt_cfg_regs #(
        .NUM_BP(NUM_BP), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
    ) u_cfg (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .bg_mode(bg_mode),
        .host_cmd_we(host_cmd_we), .host_cmd(host_cmd),
        .bp_o(bp), .pat_o(pat), .mask_o(mask),
        .en_o(en), .rmode_o(rmode), .cmd_o(cmd)
    );

    bkpt_comparator #(
        .NUM_BP(NUM_BP), .ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W)
    ) u_cmp (
        .bp(bp), .pat(pat), .mask(mask), .rmode(rmode),
        .instr_valid(instr_valid), .instr_addr(instr_addr),
        .dst_valid(dst_valid), .dst_addr(dst_addr), .dst_data(dst_data),
        .hit_vec(hit_vec)
    );

    assign any_hit = |hit_vec;

    typedef struct packed {
        logic brk;
    } brk_state_t;

    brk_state_t bs_d, bs_q;

    always_comb begin
        bs_d     = bs_q;
        bs_d.brk = en && !dbg_mode && any_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) bs_q <= '0;
        else     bs_q <= bs_d;
    end

    assign break_req   = bs_q.brk;
    assign ctrl_rdata  = {en, 1'b0, rmode, 1'b0, cmd};
    assign invalid_cmd = !cmd_known(cmd);

    // R2, R7: a break needs the master enable in the matching cycle
    p_no_break_disabled_r2: assert property (@(posedge clk) disable iff (rst)
        break_req |-> $past(en));

    // R11: no break from an instruction seen while already in debug mode
    p_dbg_suppress_r11: assert property (@(posedge clk) disable iff (rst)
        break_req |-> !$past(dbg_mode));

    // R4: every break traces back to a comparator hit one cycle earlier
    p_break_from_hit_r4: assert property (@(posedge clk) disable iff (rst)
        break_req |-> $past(any_hit));

endmodule

// File: tb/bkpt_match_unit_bench.sv
module bkpt_match_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        ctrl_we = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic        bg_mode = 1'b0;
    logic        dbg_mode = 1'b0;
    logic        host_cmd_we = 1'b0;
    logic [3:0]  host_cmd = '0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_addr = '0;
    logic        dst_valid = 1'b0;
    logic [7:0]  dst_addr = '0;
    logic [15:0] dst_data = '0;
    logic        break_req;
    logic [7:0]  ctrl_rdata;
    logic        invalid_cmd;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic  exp;
        string tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bkpt_match_unit u_bkpt_match_unit (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .bg_mode(bg_mode), .dbg_mode(dbg_mode),
        .host_cmd_we(host_cmd_we), .host_cmd(host_cmd),
        .instr_valid(instr_valid), .instr_addr(instr_addr),
        .dst_valid(dst_valid), .dst_addr(dst_addr), .dst_data(dst_data),
        .break_req(break_req), .ctrl_rdata(ctrl_rdata), .invalid_cmd(invalid_cmd)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: one expectation per registering edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            chk({15'd0, break_req}, {15'd0, it.exp}, it.tag);
        end
    end

    task automatic push(input logic exp, input string tag);
        sb_item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic quiet_instr();
        instr_valid = 1'b0;
        dst_valid   = 1'b0;
    endtask

    task automatic cyc(input logic iv, input logic [15:0] ia, input logic dv,
                       input logic [7:0] da, input logic [15:0] dd,
                       input logic exp, input string tag);
        instr_valid = iv;
        instr_addr  = ia;
        dst_valid   = dv;
        dst_addr    = da;
        dst_data    = dd;
        push(exp, tag);
        @(negedge clk);
        quiet_instr();
    endtask

    task automatic wcfg(input logic [2:0] sel, input logic [15:0] val);
        quiet_instr();
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        push(1'b0, "R4 idle during config");
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wctrl(input logic [7:0] val, input logic bg);
        quiet_instr();
        ctrl_we = 1'b1; ctrl_wdata = val; bg_mode = bg;
        push(1'b0, "R4 idle during ctrl write");
        @(negedge clk);
        ctrl_we = 1'b0; bg_mode = 1'b0;
    endtask

    task automatic hcmd(input logic [3:0] c);
        quiet_instr();
        host_cmd_we = 1'b1; host_cmd = c;
        push(1'b0, "R4 idle during host load");
        @(negedge clk);
        host_cmd_we = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk({15'd0, break_req}, 16'd0, "R1 break_req after reset");
        chk({8'd0, ctrl_rdata}, 16'h00, "R1 ctrl after reset");
        chk({15'd0, invalid_cmd}, 16'd0, "R1 invalid_cmd after reset");

        wcfg(3'd0, 16'h0100);
        wcfg(3'd1, 16'h0200);
        wcfg(3'd2, 16'h0300);
        wcfg(3'd3, 16'h0400);
        wcfg(3'd4, 16'h0512);
        wcfg(3'd5, 16'h0634);
        wcfg(3'd6, 16'hA5C3);
        wcfg(3'd7, 16'hFF00);

        // R2: disabled, matching address gives nothing; host command accepted
        cyc(1'b1, 16'h0200, 1'b0, 8'h00, 16'h0, 1'b0, "R2 match while disabled");
        hcmd(4'h2);
        chk({8'd0, ctrl_rdata}, 16'h02, "R2 host cmd loaded while disabled");

        // R3: enable write outside background mode ignored
        wctrl(8'h80, 1'b0);
        chk({8'd0, ctrl_rdata}, 16'h02, "R3 enable write without bg_mode");
        cyc(1'b1, 16'h0100, 1'b0, 8'h00, 16'h0, 1'b0, "R3 still disabled");
        wctrl(8'h80, 1'b1);
        chk({8'd0, ctrl_rdata}, 16'h82, "R3 enable write in bg_mode");

        // R4: address mode
        cyc(1'b1, 16'h0100, 1'b0, 8'h00, 16'h0, 1'b1, "R4 bp0 hit");
        cyc(1'b1, 16'h0150, 1'b0, 8'h00, 16'h0, 1'b0, "R4 miss");
        cyc(1'b1, 16'h0400, 1'b0, 8'h00, 16'h0, 1'b1, "R4 bp3 hit");
        cyc(1'b1, 16'h0512, 1'b0, 8'h00, 16'h0, 1'b1, "R4 bp4 address hit");
        cyc(1'b1, 16'h0634, 1'b0, 8'h00, 16'h0, 1'b1, "R4 bp5 address hit");
        cyc(1'b0, 16'h0634, 1'b0, 8'h00, 16'h0, 1'b0, "R4 no instr valid");
        cyc(1'b1, 16'h0200, 1'b1, 8'h12, 16'h0, 1'b1, "R4 bp1 hit");

        // R7: register mode without enable
        wctrl(8'h20, 1'b1);
        chk({8'd0, ctrl_rdata}, 16'h22, "R7 rmode set enable clear");
        cyc(1'b1, 16'h0100, 1'b0, 8'h00, 16'h0, 1'b0, "R7 address match no break");
        cyc(1'b1, 16'h0700, 1'b1, 8'h12, 16'h0, 1'b0, "R7 register match no break");

        // R5: register mode, breakpoint 4
        wctrl(8'hA0, 1'b1);
        chk({8'd0, ctrl_rdata}, 16'hA2, "R5 rmode and enable");
        cyc(1'b1, 16'h0512, 1'b0, 8'h00, 16'h0, 1'b0, "R5 bp4 ignores address");
        cyc(1'b1, 16'h0700, 1'b1, 8'h12, 16'h0, 1'b1, "R5 bp4 register hit");
        cyc(1'b1, 16'h0700, 1'b1, 8'h13, 16'h0, 1'b0, "R5 bp4 register miss");
        cyc(1'b1, 16'h0700, 1'b0, 8'h12, 16'h0, 1'b0, "R5 no destination write");
        cyc(1'b1, 16'h0300, 1'b0, 8'h00, 16'h0, 1'b1, "R5 bp2 still address");
        cyc(1'b1, 16'h0634, 1'b0, 8'h00, 16'h0, 1'b0, "R5 bp5 ignores address");

        // R6: register mode, breakpoint 5 with data pattern
        cyc(1'b1, 16'h0700, 1'b1, 8'h34, 16'hA511, 1'b1, "R6 masked pattern hit");
        cyc(1'b1, 16'h0700, 1'b1, 8'h34, 16'hA4C3, 1'b0, "R6 masked pattern miss");
        cyc(1'b1, 16'h0700, 1'b1, 8'h35, 16'hA5C3, 1'b0, "R6 wrong register");
        wcfg(3'd7, 16'h0000);
        cyc(1'b1, 16'h0700, 1'b1, 8'h34, 16'h1234, 1'b1, "R6 empty mask any data");
        wcfg(3'd7, 16'hFFFF);
        cyc(1'b1, 16'h0700, 1'b1, 8'h34, 16'hA5C2, 1'b0, "R6 full mask one bit off");
        cyc(1'b1, 16'h0700, 1'b1, 8'h34, 16'hA5C3, 1'b1, "R6 full mask exact");

        // R11: debug mode suppresses
        dbg_mode = 1'b1;
        cyc(1'b1, 16'h0100, 1'b0, 8'h00, 16'h0, 1'b0, "R11 suppressed in debug mode");
        dbg_mode = 1'b0;
        cyc(1'b1, 16'h0100, 1'b0, 8'h00, 16'h0, 1'b1, "R11 break after debug mode");

        // R10 and R8: reserved bits read 0, command field untouched
        wctrl(8'hFF, 1'b1);
        chk({8'd0, ctrl_rdata}, 16'hA2, "R10 reserved bits read zero");
        wctrl(8'h00, 1'b0);
        chk({8'd0, ctrl_rdata}, 16'h82, "R8 rmode written outside bg, cmd kept");

        // R9: command codes
        for (int c = 0; c < 16; c++) begin
            logic known;
            known = (c <= 5) || (c == 8) || (c == 9);
            hcmd(4'(c));
            chk({15'd0, invalid_cmd}, {15'd0, !known}, "R9 invalid_cmd flag");
            chk({12'd0, ctrl_rdata[3:0]}, 16'(c), "R9 code stored");
        end

        @(negedge clk);
        chk(16'(sb_q.size()), 16'd0, "R4 scoreboard drained");
        summary();
        $finish;
    end

endmodule